// File: doc/BRIEF.md
# Self-Timed Program Sequencer with Ready/Busy Status

This block sits behind the serial front end of a small nonvolatile-memory model. The front end decodes each instruction and presents it as a single-cycle strobe. The strobe carries an opcode, an address and up to sixteen data bits, and it arrives in the cycle that stands for the last required serial bit. The sequencer guards programming with two checks: a write-enable latch that comes up cleared, and a program-enable pin sampled with that strobe. When a program command is accepted, the block updates a byte-wide RAM through its write port. It then stays busy for a fixed number of system clock ticks chosen per command. The serial clock is not needed during that time.

The array is stored as bytes. In 16-bit organisation a word address selects two neighbouring bytes, the high byte at the even address. Erasing a single word or byte is one or two RAM writes. A whole-array erase and a whole-array write run as sweeps, one byte per tick, inside the busy window. A whole-array write always clears the array before it fills in the pattern.

The block also drives the ready/busy level on the serial data-out pin. Status is shown only when chip select rises after a deselect period that is long enough. Status stays shown until a start bit is seen while ready and chip select then falls.

The FSM states are ST_IDLE (waiting), ST_WORD (first byte of a single-word operation), ST_WORD2 (second byte in 16-bit organisation), ST_CLR (sweep writing 0xFF), ST_FILL (sweep writing the pattern) and ST_HOLD (waiting for the timer).

The transitions are as follows:
- ST_IDLE goes to ST_WORD for an accepted erase or write.
- ST_IDLE goes to ST_CLR for an accepted erase-all or write-all.
- ST_WORD goes to ST_WORD2 in 16-bit organisation, otherwise to ST_HOLD.
- ST_WORD2 goes to ST_HOLD.
- ST_CLR goes, at the last byte, to ST_FILL for write-all and to ST_HOLD otherwise.
- ST_FILL goes to ST_HOLD at the last byte.
- ST_HOLD goes to ST_IDLE when the timer reaches zero.

Top module: `prog_sequencer`

## Requirements
- R1: After reset the write-enable latch is clear, status_oe is 0 and ram_we is 0. A write issued before any enable command leaves the array unchanged.
- R2: The cmd_op codes are 0 read, 1 enable, 2 disable, 3 erase, 4 erase-all, 5 write, 6 write-all and 7 no-op. Enable keeps programming allowed until disable or reset. After disable, program commands are ignored.
- R3: Read and no-op strobes change neither the latch nor the array.
- R4: A program command whose strobe sees prog_en low is ignored.
- R5: Write in 8-bit organisation (org_x16=0) stores cmd_data[7:0] at byte cmd_addr. In 16-bit organisation it stores cmd_data[15:8] at byte 2*w and cmd_data[7:0] at byte 2*w+1, where w is cmd_addr[AW-2:0].
- R6: Erase sets the addressed byte, or both bytes of the addressed word, to 0xFF.
- R7: Erase-all sets every byte to 0xFF.
- R8: Write-all leaves every byte equal to the pattern. In 16-bit organisation that is cmd_data[15:8] at even bytes and cmd_data[7:0] at odd bytes. In 8-bit organisation it is cmd_data[7:0] everywhere.
- R9: Busy lasts exactly T_PROG, T_ERAL or T_WRAL ticks after the accepting edge. While status is shown, status_do is 0 when busy and 1 when ready.
- R10: status_oe rises only at a chip-select rise that follows at least MIN_DESEL low ticks, and only after a program command has been accepted. It drops on any tick where cs is low.
- R11: Holding cs low through a cycle neither aborts it nor shows status. A later qualified rise shows ready.
- R12: A start bit seen while status is shown and ready, followed by cs low, clears the indication. Later rises show nothing until the next accepted command.
- R13: Any strobe that arrives while busy is ignored, and ram_we is 0 whenever not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_addr | input | AW | Byte address (8-bit) or word address in low bits (16-bit) |
| cmd_data | input | 16 | Write data or pattern |
| org_x16 | input | 1 | 1 selects 16-bit organisation |
| prog_en | input | 1 | Program-enable pin |
| cs | input | 1 | Chip select level |
| start_bit | input | 1 | Start bit detected by the front end |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| status_oe | output | 1 | Data-out driven with status |
| status_do | output | 1 | Status level: 0 busy, 1 ready |

## Verification
The bench targets the status hand-off and the protection rules. It checks a deselect just one or two ticks too short, a cycle during which cs never rises, and a start bit followed by cs low. It also checks strobes sent in the middle of a busy window, and a disable command sent while busy.

Each of these would expose a specific fault. A design that qualifies status on any cs rise would show a spurious status_oe. One that drops the armed state when cs falls would never report ready after the long deselect. One that accepts a disable while busy would block the next program command. Separate placement checks in both organisations catch swapped bytes, and a write-all that skips the clearing sweep is caught as well.

// File: rtl/psq_pkg.sv
package psq_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDIS = 3'd2,
        OP_ERASE = 3'd3,
        OP_ERAL  = 3'd4,
        OP_WRITE = 3'd5,
        OP_WRAL  = 3'd6,
        OP_NOP   = 3'd7
    } psq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WORD  = 3'd1,
        ST_WORD2 = 3'd2,
        ST_CLR   = 3'd3,
        ST_FILL  = 3'd4,
        ST_HOLD  = 3'd5
    } psq_state_e;
endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R9
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
endmodule

// File: rtl/psq_status.sv
module psq_status #(
    parameter int MIN_DESEL = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic start_bit,
    input  logic busy,
    input  logic arm,
    output logic status_oe
);
    localparam int LW = $clog2(MIN_DESEL + 1) + 1;

    logic [LW-1:0] low_cnt_q;
    logic          cs_q;
    logic          armed_q;
    logic          clr_q;
    logic          oe_q;
    logic          desel_ok;
    logic          cs_rise;

    assign desel_ok = (low_cnt_q >= LW'(MIN_DESEL));
    assign cs_rise  = cs && !cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            cs_q      <= 1'b0;
        end else begin
            cs_q <= cs;
            if (cs) begin
                low_cnt_q <= '0;
            end else if (!desel_ok) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            clr_q   <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
            clr_q   <= 1'b0;
        end else if (!cs && clr_q) begin
            armed_q <= 1'b0;
            clr_q   <= 1'b0;
        end else if (start_bit && oe_q && !busy) begin
            clr_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (!cs) begin
            oe_q <= 1'b0;
        end else if (cs_rise && desel_ok && armed_q) begin
            oe_q <= 1'b1;
        end
    end

    assign status_oe = oe_q;

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !status_oe);

    // R11
    armed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> armed_q);

    // R12
    clear_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && cs && $past(cs)) |-> !status_oe);
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
    import psq_pkg::*;
#(
    parameter int DEPTH_B = 1024,
    parameter int AW      = 10,
    parameter int TW      = 22,
    parameter int T_PROG  = 1250000,
    parameter int T_ERAL  = 1500000,
    parameter int T_WRAL  = 3750000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [15:0]   cmd_data,
    input  logic          org_x16,
    input  logic          prog_en,
    input  logic          tmr_zero,
    output logic          go,
    output logic          busy,
    output logic [TW-1:0] tmr_load_val,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata
);
    localparam logic [AW-1:0] LAST_B = AW'(DEPTH_B - 1);

    psq_state_e    state_q, state_d;
    psq_op_e       op_in;
    psq_op_e       op_q;
    logic [AW-1:0] ptr_q;
    logic [15:0]   data_q;
    logic          x16_q;
    logic          wen_q;
    logic          idle;
    logic          is_prog;
    logic          ptr_last;
    logic [AW-1:0] word_base;

    assign op_in    = psq_op_e'(cmd_op);
    assign idle     = (state_q == ST_IDLE);
    assign busy     = !idle;
    assign ptr_last = (ptr_q == LAST_B);
    assign is_prog  = (op_in == OP_ERASE) || (op_in == OP_ERAL) ||
                      (op_in == OP_WRITE) || (op_in == OP_WRAL);
    assign go       = cmd_valid && idle && is_prog && wen_q && prog_en;
    assign word_base = org_x16 ? {cmd_addr[AW-2:0], 1'b0} : cmd_addr;

    always_comb begin
        unique case (op_in)
            OP_ERAL: tmr_load_val = TW'(T_ERAL - 1);
            OP_WRAL: tmr_load_val = TW'(T_WRAL - 1);
            default: tmr_load_val = TW'(T_PROG - 1);
        endcase
    end

    // write-enable latch: only idle strobes may touch it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
        end else if (cmd_valid && idle) begin
            if (op_in == OP_WREN) begin
                wen_q <= 1'b1;
            end else if (op_in == OP_WRDIS) begin
                wen_q <= 1'b0;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (op_in == OP_ERAL || op_in == OP_WRAL) begin
                        state_d = ST_CLR;
                    end else begin
                        state_d = ST_WORD;
                    end
                end
            end
            ST_WORD:  state_d = x16_q ? ST_WORD2 : ST_HOLD;
            ST_WORD2: state_d = ST_HOLD;
            ST_CLR: begin
                if (ptr_last) begin
                    state_d = (op_q == OP_WRAL) ? ST_FILL : ST_HOLD;
                end
            end
            ST_FILL: begin
                if (ptr_last) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operand capture and byte pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            ptr_q  <= '0;
            data_q <= '0;
            x16_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        op_q   <= op_in;
                        data_q <= cmd_data;
                        x16_q  <= org_x16;
                        ptr_q  <= (op_in == OP_ERAL || op_in == OP_WRAL) ? '0 : word_base;
                    end
                end
                ST_WORD:  ptr_q <= ptr_q + 1'b1;
                ST_CLR:   ptr_q <= ptr_last ? '0 : ptr_q + 1'b1;
                ST_FILL:  ptr_q <= ptr_q + 1'b1;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    // RAM write port
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = ptr_q;
        ram_wdata = 8'hFF;
        unique case (state_q)
            ST_WORD: begin
                ram_we = 1'b1;
                if (op_q == OP_WRITE) begin
                    ram_wdata = x16_q ? data_q[15:8] : data_q[7:0];
                end
            end
            ST_WORD2: begin
                ram_we = 1'b1;
                if (op_q == OP_WRITE) begin
                    ram_wdata = data_q[7:0];
                end
            end
            ST_CLR: begin
                ram_we = 1'b1;
            end
            ST_FILL: begin
                ram_we    = 1'b1;
                ram_wdata = (x16_q && !ptr_q[0]) ? data_q[15:8] : data_q[7:0];
            end
            default: ram_we = 1'b0;
        endcase
    end

    // R2
    go_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q && prog_en));

    // R13
    latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wen_q));

    // R9
    sweep_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmr_zero) |-> (state_q == ST_HOLD));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tmr_zero));
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
    parameter int DEPTH_B   = 1024,
    parameter int T_PROG    = 1250000,
    parameter int T_ERAL    = 1500000,
    parameter int T_WRAL    = 3750000,
    parameter int MIN_DESEL = 63,
    parameter int AW        = $clog2(DEPTH_B)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [15:0]   cmd_data,
    input  logic          org_x16,
    input  logic          prog_en,
    input  logic          cs,
    input  logic          start_bit,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          status_oe,
    output logic          status_do
);
    localparam int TMAX_A = (T_PROG > T_ERAL) ? T_PROG : T_ERAL;
    localparam int TMAX   = (TMAX_A > T_WRAL) ? TMAX_A : T_WRAL;
    localparam int TW     = $clog2(TMAX + 1);

    logic          go;
    logic          busy;
    logic          tmr_zero;
    logic [TW-1:0] tmr_load_val;

    psq_ctrl #(
        .DEPTH_B (DEPTH_B),
        .AW      (AW),
        .TW      (TW),
        .T_PROG  (T_PROG),
        .T_ERAL  (T_ERAL),
        .T_WRAL  (T_WRAL)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_addr     (cmd_addr),
        .cmd_data     (cmd_data),
        .org_x16      (org_x16),
        .prog_en      (prog_en),
        .tmr_zero     (tmr_zero),
        .go           (go),
        .busy         (busy),
        .tmr_load_val (tmr_load_val),
        .ram_we       (ram_we),
        .ram_addr     (ram_addr),
        .ram_wdata    (ram_wdata)
    );

    psq_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .run      (busy),
        .load_val (tmr_load_val),
        .zero     (tmr_zero)
    );

    psq_status #(
        .MIN_DESEL (MIN_DESEL)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .start_bit (start_bit),
        .busy      (busy),
        .arm       (go),
        .status_oe (status_oe)
    );

    assign status_do = !busy;

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_we);
endmodule

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;
    import psq_pkg::*;

    localparam int DEPTH_B   = 64;
    localparam int AW        = 6;
    localparam int T_PROG    = 12;
    localparam int T_ERAL    = 80;
    localparam int T_WRAL    = 160;
    localparam int MIN_DESEL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd7;
    logic [AW-1:0] cmd_addr = '0;
    logic [15:0]   cmd_data = '0;
    logic          org_x16 = 1'b0;
    logic          prog_en = 1'b1;
    logic          cs = 1'b0;
    logic          start_bit = 1'b0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          status_oe;
    logic          status_do;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    prog_sequencer #(
        .DEPTH_B   (DEPTH_B),
        .T_PROG    (T_PROG),
        .T_ERAL    (T_ERAL),
        .T_WRAL    (T_WRAL),
        .MIN_DESEL (MIN_DESEL),
        .AW        (AW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .org_x16   (org_x16),
        .prog_en   (prog_en),
        .cs        (cs),
        .start_bit (start_bit),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .status_oe (status_oe),
        .status_do (status_do)
    );

    // the RAM the block drives
    logic [7:0] mem [DEPTH_B];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH_B; i++) mem[i] <= 8'h00;
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
        end
    end

    // behavioural reference model
    logic [7:0] exp_mem [DEPTH_B];
    int    m_busy = 0;
    bit    m_wen = 0, m_armed = 0, m_clr = 0, m_oe = 0, m_csq = 0;
    int    m_low = 0;
    int    m_done_cnt = 0;
    string m_tag = "R1";

    task automatic m_apply(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [15:0] d, input logic x16, output int dur);
        int b;
        b = {a[AW-2:0], 1'b0};
        dur = T_PROG;
        case (op)
            OP_ERASE: begin
                m_tag = "R6";
                if (x16) begin exp_mem[b] = 8'hFF; exp_mem[b+1] = 8'hFF; end
                else exp_mem[a] = 8'hFF;
            end
            OP_WRITE: begin
                m_tag = "R5";
                if (x16) begin exp_mem[b] = d[15:8]; exp_mem[b+1] = d[7:0]; end
                else exp_mem[a] = d[7:0];
            end
            OP_ERAL: begin
                m_tag = "R7";
                dur = T_ERAL;
                for (int i = 0; i < DEPTH_B; i++) exp_mem[i] = 8'hFF;
            end
            default: begin
                m_tag = "R8";
                dur = T_WRAL;
                for (int i = 0; i < DEPTH_B; i++)
                    exp_mem[i] = (x16 && (i % 2 == 0)) ? d[15:8] : d[7:0];
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_wen = 0; m_armed = 0; m_clr = 0; m_oe = 0;
            m_csq = 0; m_low = 0;
            for (int i = 0; i < DEPTH_B; i++) exp_mem[i] = 8'h00;
        end else begin
            bit was_idle;
            bit go;
            int n_busy;
            int dur;
            was_idle = (m_busy == 0);
            go = 0;
            n_busy = was_idle ? 0 : m_busy - 1;
            if (cmd_valid && was_idle) begin
                case (cmd_op)
                    OP_WREN:  m_wen = 1;
                    OP_WRDIS: m_wen = 0;
                    OP_ERASE, OP_ERAL, OP_WRITE, OP_WRAL: begin
                        if (m_wen && prog_en) begin
                            go = 1;
                            m_apply(cmd_op, cmd_addr, cmd_data, org_x16, dur);
                            n_busy = dur;
                        end
                    end
                    default: ;
                endcase
            end
            // output enable uses pre-edge armed state
            if (!cs) m_oe = 0;
            else if (!m_csq && m_low >= MIN_DESEL && m_armed) m_oe = 1;
            if (go) begin
                m_armed = 1; m_clr = 0;
            end else if (!cs && m_clr) begin
                m_armed = 0; m_clr = 0;
            end else if (start_bit && status_oe && was_idle) begin
                m_clr = 1;
            end
            m_low = cs ? 0 : m_low + 1;
            m_csq = cs;
            if (m_busy == 1 && !go) m_done_cnt++;
            m_busy = n_busy;
        end
    end

    task automatic check1(input string r, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", r, act, exp, $time);
        end
    endtask

    task automatic check_array(input string r);
        int bad;
        int first;
        bad = 0; first = -1;
        for (int i = 0; i < DEPTH_B; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: array byte %0d actual %h expected %h (%0d bytes differ)",
                     r, first, mem[first], exp_mem[first], bad);
        end
    endtask

    // per-clock comparison away from the active edge
    int seen_done = 0;
    bit running = 0;
    always @(negedge clk) begin
        if (running && rst_n) begin
            check1("R10 status_oe", status_oe, m_oe);
            if (m_oe) check1("R9 status_do", status_do, m_busy == 0);
            if (m_busy == 0) check1("R13 ram_we idle", ram_we, 1'b0);
            if (m_done_cnt != seen_done) begin
                seen_done = m_done_cnt;
                check_array(m_tag);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic x16, input logic pe);
        cmd_op = op; cmd_addr = a; cmd_data = d; org_x16 = x16; prog_en = pe;
        cmd_valid = 1'b1;
        tick(1);
        cmd_valid = 1'b0;
        cmd_op = OP_NOP;
        prog_en = 1'b1;
    endtask

    task automatic cs_low(input int n);
        cs = 1'b0;
        tick(n);
        cs = 1'b1;
        tick(1);
    endtask

    task automatic pulse_start();
        start_bit = 1'b1;
        tick(1);
        start_bit = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy != 0) tick(1);
        tick(2);
    endtask

    initial begin
        tick(3);
        // R1: reset state
        check1("R1 status_oe reset", status_oe, 1'b0);
        check1("R1 ram_we reset", ram_we, 1'b0);
        rst_n = 1'b1;
        tick(1);
        running = 1;
        cs = 1'b1;
        tick(1);

        // R1: latch clear after reset
        cmd(OP_WRITE, 6'd5, 16'h00A5, 1'b0, 1'b1);
        tick(3);
        check_array("R1 write before enable");
        cs_low(5);
        check1("R1 no status without cycle", status_oe, 1'b0);

        // R5 single byte write with status hand-off
        cmd(OP_WREN, 6'd0, 16'h0, 1'b0, 1'b1);
        cmd(OP_WRITE, 6'd5, 16'h00A5, 1'b0, 1'b1);
        cs_low(5);
        check1("R10 status shown after long deselect", status_oe, 1'b1);
        check1("R9 busy shown", status_do, 1'b0);
        wait_idle();
        check1("R9 ready shown", status_do, 1'b1);
        pulse_start();
        cs_low(5);
        tick(1);
        check1("R12 cleared after start and cs low", status_oe, 1'b0);

        // R5 16-bit write, R10 short deselect, R13 strobes during busy
        cmd(OP_WRITE, 6'd3, 16'h1234, 1'b1, 1'b1);
        cs_low(2);
        check1("R10 short deselect hides status", status_oe, 1'b0);
        cs_low(5);
        cmd(OP_WRITE, 6'd9, 16'h0077, 1'b0, 1'b1);
        cmd(OP_WRDIS, 6'd0, 16'h0, 1'b0, 1'b1);
        cmd(OP_ERAL, 6'd0, 16'h0, 1'b0, 1'b1);
        wait_idle();
        pulse_start();
        cs_low(5);

        // R6 erase byte and word; R13 the disable above must not have landed
        cmd(OP_ERASE, 6'd6, 16'h0, 1'b0, 1'b1);
        wait_idle();
        cmd(OP_ERASE, 6'd2, 16'h0, 1'b1, 1'b1);
        wait_idle();

        // R4 program-enable pin low
        cmd(OP_WRITE, 6'd10, 16'h0077, 1'b0, 1'b0);
        cmd(OP_WRAL, 6'd0, 16'h5555, 1'b0, 1'b0);
        tick(3);
        check_array("R4 pin low ignored");

        // R3 read and no-op leave latch and array
        cmd(OP_READ, 6'd11, 16'h0, 1'b0, 1'b1);
        cmd(OP_NOP, 6'd11, 16'hFFFF, 1'b0, 1'b1);
        tick(2);
        check_array("R3 read no effect");
        cmd(OP_WRITE, 6'd11, 16'h005A, 1'b0, 1'b1);
        wait_idle();

        // R7, R8
        cmd(OP_ERAL, 6'd0, 16'h0, 1'b0, 1'b1);
        wait_idle();
        cmd(OP_WRITE, 6'd20, 16'h0011, 1'b0, 1'b1);
        wait_idle();
        cmd(OP_WRAL, 6'd0, 16'hBEEF, 1'b1, 1'b1);
        wait_idle();
        cmd(OP_WRAL, 6'd0, 16'h003C, 1'b0, 1'b1);
        wait_idle();

        // R11 cs held low through a whole cycle
        cmd(OP_ERASE, 6'd0, 16'h0, 1'b0, 1'b1);
        cs = 1'b0;
        tick(T_PROG + 6);
        check1("R11 hidden while cs low", status_oe, 1'b0);
        cs = 1'b1;
        tick(2);
        check1("R11 late rise shows", status_oe, 1'b1);
        check1("R11 late rise ready", status_do, 1'b1);
        pulse_start();
        cs_low(5);
        tick(1);
        check1("R12 cleared", status_oe, 1'b0);

        // R2 disable blocks programming
        cmd(OP_WRDIS, 6'd0, 16'h0, 1'b0, 1'b1);
        cmd(OP_ERASE, 6'd1, 16'h0, 1'b0, 1'b1);
        tick(3);
        check_array("R2 disabled erase ignored");
        cs_low(5);
        check1("R2 no cycle after disable", status_oe, 1'b0);

        tick(2);
        running = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule